// File: doc/BRIEF.md
# Power-Managed Mode Wake Controller

This controller decides which clocks a small processor core and its peripherals receive. From reset it either holds the core until the primary oscillator is ready, or it lets the core start at once on the internal RC oscillator (two-speed start-up or fail-safe monitoring) and moves to the primary clock when that clock is ready. A sleep-instruction strobe puts the core into RC Idle, where the peripherals keep running on the internal RC clock and the CPU clock stops. It can also put the core into Sleep, where both clocks stop. Either kind of entry shuts the primary oscillator down.

An enabled interrupt flag or a watchdog time-out ends Idle or Sleep. A fixed delay follows, with the CPU held off and the peripherals on the RC clock. Execution then resumes on the RC clock. An interrupt wake asks for a branch to the vector only when the global interrupt enable is set. A watchdog time-out during a run mode produces a watchdog reset instead of a wake. The idle-enable and clock-select bits are held in the block. Only the running CPU writes them, and a wake-up never alters them.

Mode codes on `pm_mode`: 0 start-up hold, 1 run on primary, 2 run on RC, 3 RC idle, 4 sleep, 5 wake delay. `per_clk_src` is 1 for the primary clock and 0 for the RC clock.

Top module: `pm_wake_ctrl`

## Requirements
- R1: After reset with `two_speed_on` and `fscm_on` low, the mode is 0 with `cpu_clk_en`=0, `per_clk_en`=0, `pri_osc_en`=1 and `osc_start_ok`=0. It stays there until `pri_ready` is high at a clock edge. After that edge the mode is 1 with `cpu_clk_en`=1, `per_clk_en`=1, `per_clk_src`=1 and `osc_start_ok`=1.
- R2: After reset with `two_speed_on` or `fscm_on` high and `pri_ready` low, the mode is 2 one clock after reset release, with `cpu_clk_en`=1, `per_clk_src`=0, `pri_osc_en`=1 and `osc_start_ok`=0.
- R3: A `sleep_stb` with stored idle bit 1 enters mode 3 at the next edge when the current mode is 2, or when stored `sel_cfg[1]`=1. Mode 3 has `cpu_clk_en`=0, `per_clk_en`=1 and `per_clk_src`=0. `sel_cfg[0]` has no effect on the outcome.
- R4: A `sleep_stb` in mode 1 with stored idle bit 1 and `sel_cfg[1]`=0 is ignored: the mode stays 1 and `cpu_clk_en` stays 1.
- R5: A `sleep_stb` in mode 1 or 2 with stored idle bit 0 enters mode 4, where `cpu_clk_en`=0 and `per_clk_en`=0. `rc_osc_en` equals `wdt_on | fscm_on` in mode 4 and is 1 in every other mode.
- R6: On entry to mode 3 or 4, `pri_osc_en` and `osc_start_ok` become 0. This also happens when the primary oscillator had not yet reported ready.
- R7: In mode 3 or 4, a wake event moves to mode 5 at the next edge. A wake event is `wdt_timeout`=1 or any bit set in `irq_flag & irq_en`; a flag whose enable is 0 does not wake. Mode 5 has `cpu_clk_en`=0, `per_clk_en`=1 and `per_clk_src`=0, and lasts exactly `WAKE_DLY` cycles. Mode 2 follows, with `cpu_clk_en`=1.
- R8: `vector_req` is 1 for exactly the first mode-2 cycle after a wake. It is raised only when the wake came from an interrupt and `gie` was 1 at the wake event. A watchdog wake or `gie`=0 leaves it 0.
- R9: `wdt_timeout` in mode 1 or 2 sets `wdt_reset` to 1 for the following cycle. In modes 3 and 4 it causes only a wake, and `wdt_reset` stays 0.
- R10: `idle_cfg`/`sel_cfg` reset to 0 and load `idle_in`/`sel_in` on the edge where `cfg_wr`=1 and `cpu_clk_en`=1. A `cfg_wr` while `cpu_clk_en`=0 is ignored, and a wake-up leaves them unchanged.
- R11: In mode 2 with `sel_cfg[1]`=0, `pri_osc_en` becomes 1 at the next edge. Once it is 1 and `pri_ready` is 1, the mode moves to 1 with `osc_start_ok`=1. With `sel_cfg[1]`=1, `pri_osc_en` is driven to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_stb | input | 1 | Sleep instruction executed |
| cfg_wr | input | 1 | Write strobe for the mode-control bits |
| idle_in | input | 1 | Idle-enable value to store |
| sel_in | input | 2 | Clock-select value to store |
| irq_flag | input | NUM_IRQ | Interrupt flags |
| irq_en | input | NUM_IRQ | Interrupt enables |
| gie | input | 1 | Global interrupt enable |
| wdt_timeout | input | 1 | Watchdog time-out |
| wdt_on | input | 1 | Watchdog enabled |
| fscm_on | input | 1 | Fail-safe clock monitoring enabled |
| two_speed_on | input | 1 | Two-speed start-up enabled |
| pri_ready | input | 1 | Primary oscillator ready |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| per_clk_src | output | 1 | Peripheral/CPU clock source, 1 primary, 0 RC |
| rc_osc_en | output | 1 | Internal RC oscillator enable |
| pri_osc_en | output | 1 | Primary oscillator enable |
| osc_start_ok | output | 1 | Primary oscillator start-up status |
| vector_req | output | 1 | Branch-to-vector request |
| wdt_reset | output | 1 | Watchdog reset request |
| idle_cfg | output | 1 | Stored idle-enable bit |
| sel_cfg | output | 2 | Stored clock-select bits |
| pm_mode | output | 3 | Current mode code |

## Verification
A wrong mode register shows at once on `pm_mode` and on the clock enables in the next cycle. A wrong delay count stretches or shortens the stretch of low `cpu_clk_en` after a wake, so the first run cycle is checked at its exact position. A lost or stale vector flag shows as a missing or misplaced one-cycle `vector_req` in that same first run cycle. A corrupted configuration register shows on `idle_cfg`/`sel_cfg`, and also in the outcome of the next sleep strobe or in whether the primary oscillator restarts after wake.

// File: rtl/pm_wake_pkg.sv
package pm_wake_pkg;

    typedef enum logic [2:0] {
        PM_HOLD    = 3'd0,
        PM_RUN_PRI = 3'd1,
        PM_RUN_RC  = 3'd2,
        PM_IDLE_RC = 3'd3,
        PM_SLEEP   = 3'd4,
        PM_WAKE    = 3'd5
    } pm_mode_e;

    typedef struct packed {
        pm_mode_e mode;
        logic     pri_en;
        logic     osc_ok;
        logic     vec_pend;
        logic     vec_req;
        logic     wdt_rst;
    } pm_state_t;

    typedef struct packed {
        logic cpu_en;
        logic per_en;
        logic per_src;
        logic rc_en;
    } pm_clk_t;

    typedef struct packed {
        logic       idle;
        logic [1:0] sel;
    } pm_cfg_t;

endpackage

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
    import pm_wake_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       cpu_running,
    input  logic       idle_in,
    input  logic [1:0] sel_in,
    output pm_cfg_t    cfg_q_o
);
    pm_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && cpu_running) begin
            cfg_d.idle = idle_in;
            cfg_d.sel  = sel_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_q_o = cfg_q;
endmodule

// File: rtl/pm_wake_detect.sv
module pm_wake_detect #(
    parameter int NUM_IRQ = 4
) (
    input  logic [NUM_IRQ-1:0] irq_flag,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               wdt_timeout,
    output logic               irq_wake,
    output logic               any_wake
);
    logic [NUM_IRQ-1:0] hit;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
        assign hit[i] = irq_flag[i] & irq_en[i];
    end

    assign irq_wake = |hit;
    assign any_wake = irq_wake | wdt_timeout;
endmodule

// File: rtl/pm_delay_timer.sv
module pm_delay_timer #(
    parameter int DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CW = (DLY > 1) ? $clog2(DLY) : 1;
    localparam logic [CW-1:0] LOAD = CW'(DLY - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          busy_d, busy_q;

    always_comb begin
        cnt_d  = cnt_q;
        busy_d = busy_q;
        if (start) begin
            cnt_d  = LOAD;
            busy_d = 1'b1;
        end else if (busy_q) begin
            if (cnt_q == '0) busy_d = 1'b0;
            else             cnt_d  = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            busy_q <= busy_d;
        end
    end

    assign done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/pm_clk_decode.sv
module pm_clk_decode
    import pm_wake_pkg::*;
(
    input  pm_mode_e mode,
    input  logic     wdt_on,
    input  logic     fscm_on,
    output pm_clk_t  clk_o
);
    always_comb begin
        clk_o = '{cpu_en: 1'b0, per_en: 1'b0, per_src: 1'b0, rc_en: 1'b1};
        case (mode)
            PM_RUN_PRI: begin
                clk_o.cpu_en  = 1'b1;
                clk_o.per_en  = 1'b1;
                clk_o.per_src = 1'b1;
            end
            PM_RUN_RC: begin
                clk_o.cpu_en = 1'b1;
                clk_o.per_en = 1'b1;
            end
            PM_IDLE_RC, PM_WAKE: clk_o.per_en = 1'b1;
            PM_SLEEP:            clk_o.rc_en  = wdt_on | fscm_on;
            default: ;
        endcase
    end
endmodule

// File: rtl/pm_wake_ctrl.sv
module pm_wake_ctrl
    import pm_wake_pkg::*;
#(
    parameter int NUM_IRQ  = 4,
    parameter int WAKE_DLY = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep_stb,
    input  logic               cfg_wr,
    input  logic               idle_in,
    input  logic [1:0]         sel_in,
    input  logic [NUM_IRQ-1:0] irq_flag,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               gie,
    input  logic               wdt_timeout,
    input  logic               wdt_on,
    input  logic               fscm_on,
    input  logic               two_speed_on,
    input  logic               pri_ready,
    output logic               cpu_clk_en,
    output logic               per_clk_en,
    output logic               per_clk_src,
    output logic               rc_osc_en,
    output logic               pri_osc_en,
    output logic               osc_start_ok,
    output logic               vector_req,
    output logic               wdt_reset,
    output logic               idle_cfg,
    output logic [1:0]         sel_cfg,
    output logic [2:0]         pm_mode
);
    pm_state_t st_d, st_q;
    pm_cfg_t   cfg;
    pm_clk_t   clks;
    logic      irq_wake, any_wake, tmr_start, tmr_done, running;

    pm_cfg_regs u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_wr),
        .cpu_running (clks.cpu_en),
        .idle_in     (idle_in),
        .sel_in      (sel_in),
        .cfg_q_o     (cfg)
    );

    pm_wake_detect #(.NUM_IRQ(NUM_IRQ)) u_wdet (
        .irq_flag    (irq_flag),
        .irq_en      (irq_en),
        .wdt_timeout (wdt_timeout),
        .irq_wake    (irq_wake),
        .any_wake    (any_wake)
    );

    pm_delay_timer #(.DLY(WAKE_DLY)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .done  (tmr_done)
    );

    pm_clk_decode u_dec (
        .mode    (st_q.mode),
        .wdt_on  (wdt_on),
        .fscm_on (fscm_on),
        .clk_o   (clks)
    );

    assign running = (st_q.mode == PM_RUN_PRI) || (st_q.mode == PM_RUN_RC);

    always_comb begin
        st_d         = st_q;
        st_d.vec_req = 1'b0;
        st_d.wdt_rst = wdt_timeout && running;
        tmr_start    = 1'b0;
        case (st_q.mode)
            PM_HOLD: begin
                if (pri_ready) begin
                    st_d.mode   = PM_RUN_PRI;
                    st_d.osc_ok = 1'b1;
                end else if (two_speed_on || fscm_on) begin
                    st_d.mode = PM_RUN_RC;
                end
            end
            PM_RUN_PRI: begin
                if (sleep_stb && !cfg.idle) begin
                    st_d.mode   = PM_SLEEP;
                    st_d.pri_en = 1'b0;
                    st_d.osc_ok = 1'b0;
                end else if (sleep_stb && cfg.sel[1]) begin
                    st_d.mode   = PM_IDLE_RC;
                    st_d.pri_en = 1'b0;
                    st_d.osc_ok = 1'b0;
                end
            end
            PM_RUN_RC: begin
                if (sleep_stb) begin
                    st_d.mode   = cfg.idle ? PM_IDLE_RC : PM_SLEEP;
                    st_d.pri_en = 1'b0;
                    st_d.osc_ok = 1'b0;
                end else if (cfg.sel[1]) begin
                    st_d.pri_en = 1'b0;
                end else begin
                    st_d.pri_en = 1'b1;
                    if (st_q.pri_en && pri_ready) begin
                        st_d.mode   = PM_RUN_PRI;
                        st_d.osc_ok = 1'b1;
                    end
                end
            end
            PM_IDLE_RC, PM_SLEEP: begin
                if (any_wake) begin
                    st_d.mode     = PM_WAKE;
                    st_d.vec_pend = irq_wake && gie;
                    tmr_start     = 1'b1;
                end
            end
            PM_WAKE: begin
                if (tmr_done) begin
                    st_d.mode     = PM_RUN_RC;
                    st_d.vec_req  = st_q.vec_pend;
                    st_d.vec_pend = 1'b0;
                end
            end
            default: st_d.mode = PM_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: PM_HOLD, pri_en: 1'b1, osc_ok: 1'b0,
                      vec_pend: 1'b0, vec_req: 1'b0, wdt_rst: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_clk_en   = clks.cpu_en;
    assign per_clk_en   = clks.per_en;
    assign per_clk_src  = clks.per_src;
    assign rc_osc_en    = clks.rc_en;
    assign pri_osc_en   = st_q.pri_en;
    assign osc_start_ok = st_q.osc_ok;
    assign vector_req   = st_q.vec_req;
    assign wdt_reset    = st_q.wdt_rst;
    assign idle_cfg     = cfg.idle;
    assign sel_cfg      = cfg.sel;
    assign pm_mode      = st_q.mode;
endmodule

// File: rtl/pm_wake_ctrl_chk.sv
module pm_wake_ctrl_chk #(
    parameter int WAKE_DLY = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wdt_timeout,
    input logic       cpu_clk_en,
    input logic       per_clk_en,
    input logic       pri_osc_en,
    input logic       osc_start_ok,
    input logic       vector_req,
    input logic       wdt_reset,
    input logic       idle_cfg,
    input logic [1:0] sel_cfg,
    input logic [2:0] pm_mode
);
    localparam logic [15:0] DLY16 = 16'(WAKE_DLY);
    logic [15:0] wcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              wcnt <= '0;
        else if (pm_mode == 3'd5) wcnt <= wcnt + 16'd1;
        else                     wcnt <= '0;
    end

    assert_wake_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_mode == 3'd2 && $past(pm_mode) == 3'd5) |-> wcnt == DLY16);

    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_clk_en |=> $stable({idle_cfg, sel_cfg}));

    assert_wdt_rst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset |-> $past(wdt_timeout) && ($past(pm_mode) == 3'd1 || $past(pm_mode) == 3'd2));

    assert_lp_pri_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_mode == 3'd3 || pm_mode == 3'd4) |-> !pri_osc_en && !osc_start_ok);

    assert_vector_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vector_req |-> pm_mode == 3'd2 && $past(pm_mode) == 3'd5);

    assert_sleep_clk_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pm_mode == 3'd4 |-> !per_clk_en && !cpu_clk_en);

    assert_osc_ok_R1: assert property (@(posedge clk) disable iff (!rst_n)
        osc_start_ok |-> pri_osc_en);
endmodule

bind pm_wake_ctrl pm_wake_ctrl_chk #(.WAKE_DLY(WAKE_DLY)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wdt_timeout  (wdt_timeout),
    .cpu_clk_en   (cpu_clk_en),
    .per_clk_en   (per_clk_en),
    .pri_osc_en   (pri_osc_en),
    .osc_start_ok (osc_start_ok),
    .vector_req   (vector_req),
    .wdt_reset    (wdt_reset),
    .idle_cfg     (idle_cfg),
    .sel_cfg      (sel_cfg),
    .pm_mode      (pm_mode)
);

// File: tb/pm_wake_ctrl_tb.sv
module pm_wake_ctrl_tb;
    localparam int NI = 4;
    localparam int D  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_stb = 0, cfg_wr = 0, idle_in = 0, gie = 0, wdt_timeout = 0;
    logic wdt_on = 0, fscm_on = 0, two_speed_on = 0, pri_ready = 0;
    logic [1:0] sel_in = '0;
    logic [NI-1:0] irq_flag = '0, irq_en = '0;
    logic cpu_clk_en, per_clk_en, per_clk_src, rc_osc_en, pri_osc_en;
    logic osc_start_ok, vector_req, wdt_reset, idle_cfg;
    logic [1:0] sel_cfg;
    logic [2:0] pm_mode;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    pm_wake_ctrl #(.NUM_IRQ(NI), .WAKE_DLY(D)) u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_stb(sleep_stb), .cfg_wr(cfg_wr),
        .idle_in(idle_in), .sel_in(sel_in), .irq_flag(irq_flag), .irq_en(irq_en),
        .gie(gie), .wdt_timeout(wdt_timeout), .wdt_on(wdt_on), .fscm_on(fscm_on),
        .two_speed_on(two_speed_on), .pri_ready(pri_ready),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .per_clk_src(per_clk_src),
        .rc_osc_en(rc_osc_en), .pri_osc_en(pri_osc_en), .osc_start_ok(osc_start_ok),
        .vector_req(vector_req), .wdt_reset(wdt_reset), .idle_cfg(idle_cfg),
        .sel_cfg(sel_cfg), .pm_mode(pm_mode)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic ts, input logic fs, input logic pr);
        rst_n = 1'b0;
        two_speed_on = ts; fscm_on = fs; pri_ready = pr;
        sleep_stb = 0; cfg_wr = 0; wdt_timeout = 0; irq_flag = '0; irq_en = '0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic write_cfg(input logic id, input logic [1:0] s);
        cfg_wr = 1; idle_in = id; sel_in = s;
        step();
        cfg_wr = 0;
    endtask

    task automatic strobe();
        sleep_stb = 1;
        step();
        sleep_stb = 0;
    endtask

    task automatic wake_window(input string req);
        for (int k = 0; k < D; k++) begin
            chk(req, "wake mode", pm_mode, 5);
            chk(req, "wake cpu", cpu_clk_en, 0);
            chk(req, "wake per", per_clk_en, 1);
            chk(req, "wake src", per_clk_src, 0);
            step();
        end
        chk(req, "resume mode", pm_mode, 2);
        chk(req, "resume cpu", cpu_clk_en, 1);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        // R1: plain start-up hold
        do_reset(0, 0, 0);
        chk("R1", "mode", pm_mode, 0);
        chk("R1", "cpu", cpu_clk_en, 0);
        chk("R1", "per", per_clk_en, 0);
        chk("R1", "pri_en", pri_osc_en, 1);
        chk("R1", "ok", osc_start_ok, 0);
        chk("R10", "idle reset", idle_cfg, 0);
        chk("R10", "sel reset", sel_cfg, 0);
        step(); step(); step();
        chk("R1", "still hold", pm_mode, 0);
        pri_ready = 1;
        step();
        chk("R1", "mode", pm_mode, 1);
        chk("R1", "cpu", cpu_clk_en, 1);
        chk("R1", "per", per_clk_en, 1);
        chk("R1", "src", per_clk_src, 1);
        chk("R1", "ok", osc_start_ok, 1);

        // R9: watchdog in run gives reset
        wdt_timeout = 1;
        step();
        wdt_timeout = 0;
        chk("R9", "wdt_reset run", wdt_reset, 1);
        chk("R9", "mode kept", pm_mode, 1);
        step();
        chk("R9", "wdt_reset pulse end", wdt_reset, 0);

        // Sweep entry from primary run over idle bit and select bits
        for (int s = 0; s < 4; s++) begin
            for (int id = 0; id < 2; id++) begin
                int exp_mode;
                logic [1:0] sv;
                sv = 2'(s);
                do_reset(0, 0, 1);
                step();
                write_cfg(id[0], sv);
                chk("R10", "idle load", idle_cfg, id);
                chk("R10", "sel load", sel_cfg, s);
                strobe();
                exp_mode = (id != 0) ? (sv[1] ? 3 : 1) : 4;
                chk(exp_mode == 1 ? "R4" : (exp_mode == 3 ? "R3" : "R5"), "entry mode", pm_mode, exp_mode);
                if (exp_mode == 1) begin
                    chk("R4", "cpu kept", cpu_clk_en, 1);
                end else begin
                    chk("R6", "pri off", pri_osc_en, 0);
                    chk("R6", "ok off", osc_start_ok, 0);
                    chk("R3", "cpu off", cpu_clk_en, 0);
                    chk("R5", "per", per_clk_en, exp_mode == 3 ? 1 : 0);
                    if (exp_mode == 4) begin
                        for (int w = 0; w < 4; w++) begin
                            wdt_on = w[0]; fscm_on = w[1];
                            #1;
                            chk("R5", "rc_en sleep", rc_osc_en, (w != 0) ? 1 : 0);
                        end
                        wdt_on = 0; fscm_on = 0;
                    end else begin
                        chk("R5", "rc_en idle", rc_osc_en, 1);
                        chk("R3", "src rc", per_clk_src, 0);
                    end
                    wdt_timeout = 1;
                    step();
                    wdt_timeout = 0;
                    chk("R9", "no wdt_reset in low power", wdt_reset, 0);
                    wake_window("R7");
                    chk("R8", "no vector on wdt wake", vector_req, 0);
                    chk("R10", "idle kept", idle_cfg, id);
                    chk("R10", "sel kept", sel_cfg, s);
                    step();
                    chk("R11", "pri restart", pri_osc_en, sv[1] ? 0 : 1);
                end
            end
        end

        // Two-speed start-up, then idle before primary ready, interrupt wakes
        do_reset(1, 0, 0);
        step();
        chk("R2", "mode", pm_mode, 2);
        chk("R2", "cpu", cpu_clk_en, 1);
        chk("R2", "src", per_clk_src, 0);
        chk("R2", "pri_en", pri_osc_en, 1);
        chk("R2", "ok", osc_start_ok, 0);
        write_cfg(1, 2'b10);
        strobe();
        chk("R3", "idle from rc", pm_mode, 3);
        chk("R6", "pri off early", pri_osc_en, 0);
        for (int i = 0; i < NI; i++) begin
            for (int g = 0; g < 2; g++) begin
                gie = g[0];
                irq_flag = '0; irq_flag[i] = 1'b1;
                irq_en = ~irq_flag;
                step();
                chk("R7", "masked flag", pm_mode, 3);
                irq_en = irq_flag;
                step();
                irq_flag = '0; irq_en = '0;
                wake_window("R7");
                chk("R8", "vector first cycle", vector_req, g);
                step();
                chk("R8", "vector single", vector_req, 0);
                strobe();
                chk("R3", "re-idle", pm_mode, 3);
            end
        end

        // R10 write ignored while stopped; R11 return to primary after wake
        do_reset(0, 0, 1);
        step();
        write_cfg(0, 2'b00);
        strobe();
        chk("R5", "sleep", pm_mode, 4);
        cfg_wr = 1; idle_in = 1; sel_in = 2'b11;
        step();
        cfg_wr = 0;
        chk("R10", "idle write ignored", idle_cfg, 0);
        chk("R10", "sel write ignored", sel_cfg, 0);
        gie = 1; irq_flag = 4'b0100; irq_en = 4'b0100;
        step();
        irq_flag = '0; irq_en = '0;
        wake_window("R7");
        chk("R8", "vector sleep wake", vector_req, 1);
        chk("R11", "pri still off", pri_osc_en, 0);
        step();
        chk("R11", "pri on", pri_osc_en, 1);
        chk("R11", "still rc", pm_mode, 2);
        step();
        chk("R11", "to primary", pm_mode, 1);
        chk("R11", "ok", osc_start_ok, 1);
        chk("R11", "src", per_clk_src, 1);

        finish_run();
    end
endmodule